// File: doc/BRIEF.md
# Instruction Exception Vector Classifier

This block takes the first opcode word of an instruction at decode time and decides whether the instruction must raise an exception. If it must, the block gives the vector number and the matching vector table offset. The decision depends on three things: the opcode line class, the current privilege level, and the outcome of the auxiliary bus cycles the block itself runs.

Most verdicts come straight from the opcode word. Coprocessor-class opcodes are different. For these, the block runs a short probe: it raises a CPU-space request aimed at the selected coprocessor and holds it until the bus answers with either an acknowledge or a bus error. A breakpoint-acknowledge cycle that ended in a bus error is reported through a separate input, and the block turns it into an illegal-instruction verdict.

Each exception is signalled by a one-cycle strobe. While the strobe is high, the vector number and the byte offset are valid. A new decode is taken only while the block reports itself ready.

Top module: `opexc_classifier`

## Requirements
- R1: An accepted opword whose bits 15:12 are 4'hA raises vector 10 in both privilege levels.
- R2: An accepted opword equal to 16'h4AFC raises vector 4.
- R3: An accepted opword of 16'h4E7A or 16'h4E7B raises vector 8 in user mode. In supervisor mode it raises vector 4 when ext_word[11:0] is none of 12'h000, 12'h001, 12'h002, 12'h800, 12'h801, 12'h802, 12'h803 and 12'h804, and raises nothing when it is one of them.
- R4: A bkpt_berr pulse seen while ready raises vector 4. If dec_valid is high in the same cycle, bkpt_berr takes precedence and that decode is dropped.
- R5: An opword with bits 15:12 = 4'hF and bits 11:9 = 3'b000 raises nothing when mmu_ext_ok is 1. When mmu_ext_ok is 0, it raises vector 11 in supervisor mode and vector 8 in user mode.
- R6: An opword with bits 15:12 = 4'hF and bits 11:9 not 3'b000 raises cp_req from the cycle after acceptance. While cp_req is high, cp_space = 4'h2 and cp_id = opword[11:9]. cp_req stays high until a response arrives in the waiting phase; a response in the first request cycle is ignored.
- R7: A probe answered by cp_berr raises vector 11. cp_berr wins if cp_ack arrives in the same cycle.
- R8: A probe answered by cp_ack alone raises nothing, and cp_req drops on the next cycle.
- R9: An opword of 16'h4E40 + n (n = bits 3:0) raises vector 32 + n.
- R10: Whenever exc_valid is high, exc_offset equals exc_vector times 4.
- R11: exc_valid is high for exactly one cycle. It rises in the cycle after acceptance or after the probe response. ready is high only when idle, and dec_valid is ignored while ready is low.
- R12: After reset, ready is 1 and exc_valid and cp_req are 0.
- R13: Any accepted opword not covered above raises nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Opword presented for classification |
| opword | input | 16 | First instruction word |
| supervisor | input | 1 | 1 = supervisor, 0 = user privilege |
| mmu_ext_ok | input | 1 | Extension words of a memory-management opcode are a defined pattern |
| ext_word | input | 16 | First extension word (control register select for 4E7A/4E7B) |
| bkpt_berr | input | 1 | Breakpoint-acknowledge cycle ended in bus error |
| cp_ack | input | 1 | Coprocessor probe acknowledged normally |
| cp_berr | input | 1 | Coprocessor probe ended in bus error |
| ready | output | 1 | Idle; a decode or breakpoint report is accepted |
| cp_req | output | 1 | CPU-space probe request |
| cp_space | output | 4 | CPU-space type of the request (2 while requesting) |
| cp_id | output | 3 | Addressed coprocessor number |
| exc_valid | output | 1 | One-cycle exception strobe |
| exc_vector | output | 8 | Exception vector number |
| exc_offset | output | 10 | Vector table byte offset |

## Verification
Several properties are checked by assertions on every cycle:
- the exception strobe is a single-cycle pulse, and the offset agrees with the vector;
- the probe request is held, with a stable coprocessor number and a CPU-space type of 2;
- a probe bus error, an A-line decode or a breakpoint bus error is followed one cycle later by the right vector.

Other behaviours can only be shown by the bench's scenarios:
- the full opword-to-vector mapping, including the privilege splits and the control-register list;
- that an acknowledge in the first request cycle is ignored;
- that a decode arriving while busy has no effect;
- that a breakpoint report wins over a simultaneous decode.

// File: rtl/opexc_pkg.sv
package opexc_pkg;
  localparam int VEC_W = 8;
  localparam int OFF_W = VEC_W + 2;
  localparam int CP_W  = 3;

  localparam logic [VEC_W-1:0] VEC_ILLEGAL   = 8'd4;
  localparam logic [VEC_W-1:0] VEC_PRIVILEGE = 8'd8;
  localparam logic [VEC_W-1:0] VEC_ALINE     = 8'd10;
  localparam logic [VEC_W-1:0] VEC_FLINE     = 8'd11;
  localparam logic [VEC_W-1:0] VEC_TRAP_BASE = 8'd32;

  typedef enum logic [1:0] {ACT_NONE, ACT_RAISE, ACT_PROBE} act_e;

  typedef struct packed {
    act_e             act;
    logic [VEC_W-1:0] vec;
    logic [CP_W-1:0]  cp;
  } verdict_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} pst_e;

  // Vector table entries are four bytes wide.
  function automatic logic [OFF_W-1:0] vec_to_offset(input logic [VEC_W-1:0] v);
    return {v, 2'b00};
  endfunction

  function automatic logic [VEC_W-1:0] trap_vector(input logic [3:0] n);
    return VEC_TRAP_BASE + {4'd0, n};
  endfunction

  // Control registers accepted by the move-to/from-control opcode.
  function automatic logic ctrl_reg_known(input logic [11:0] r);
    case (r)
      12'h000, 12'h001, 12'h002,
      12'h800, 12'h801, 12'h802, 12'h803, 12'h804: return 1'b1;
      default:                                     return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/opexc_decode.sv
module opexc_decode
  import opexc_pkg::*;
#(
  parameter logic [15:0] ILLEGAL_WORD = 16'h4AFC,
  parameter logic [14:0] MOVEC_HI     = 15'h273D,
  parameter logic [11:0] TRAP_HI      = 12'h4E4
) (
  input  logic [15:0] opword,
  input  logic        supervisor,
  input  logic        mmu_ext_ok,
  input  logic [15:0] ext_word,
  output verdict_t    verdict
);
  logic [3:0]      line;
  logic [CP_W-1:0] cp_field;

  assign line     = opword[15:12];
  assign cp_field = opword[11:9];

  always_comb begin
    verdict = '{act: ACT_NONE, vec: '0, cp: cp_field};
    if (line == 4'hA) begin
      verdict.act = ACT_RAISE;
      verdict.vec = VEC_ALINE;
    end else if (line == 4'hF) begin
      if (cp_field == '0) begin
        if (!mmu_ext_ok) begin
          verdict.act = ACT_RAISE;
          verdict.vec = supervisor ? VEC_FLINE : VEC_PRIVILEGE;
        end
      end else begin
        verdict.act = ACT_PROBE;
      end
    end else if (opword[15:4] == TRAP_HI) begin
      verdict.act = ACT_RAISE;
      verdict.vec = trap_vector(opword[3:0]);
    end else if (opword == ILLEGAL_WORD) begin
      verdict.act = ACT_RAISE;
      verdict.vec = VEC_ILLEGAL;
    end else if (opword[15:1] == MOVEC_HI) begin
      if (!supervisor) begin
        verdict.act = ACT_RAISE;
        verdict.vec = VEC_PRIVILEGE;
      end else if (!ctrl_reg_known(ext_word[11:0])) begin
        verdict.act = ACT_RAISE;
        verdict.vec = VEC_ILLEGAL;
      end
    end
  end
endmodule

// File: rtl/opexc_seq.sv
module opexc_seq
  import opexc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic             bkpt_berr,
  input  verdict_t         verdict,
  input  logic             cp_ack,
  input  logic             cp_berr,
  output pst_e             state,
  output logic             cp_req,
  output logic [CP_W-1:0]  cp_id,
  output logic             exc_valid,
  output logic [VEC_W-1:0] exc_vector,
  output logic             ev_accept,
  output logic             ev_bkpt,
  output logic             ev_probe_fail,
  output logic             ev_probe_ok
);
  pst_e             st_q;
  logic             pend_q;
  logic [VEC_W-1:0] vec_q;
  logic [CP_W-1:0]  cp_q;

  assign ev_bkpt       = (st_q == ST_IDLE) && bkpt_berr;
  assign ev_accept     = (st_q == ST_IDLE) && dec_valid && !bkpt_berr;
  assign ev_probe_fail = (st_q == ST_WAIT) && cp_berr;
  assign ev_probe_ok   = (st_q == ST_WAIT) && cp_ack && !cp_berr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      vec_q  <= '0;
      cp_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (ev_bkpt) begin
            pend_q <= 1'b1;
            vec_q  <= VEC_ILLEGAL;
            st_q   <= ST_DONE;
          end else if (ev_accept) begin
            case (verdict.act)
              ACT_RAISE: begin
                pend_q <= 1'b1;
                vec_q  <= verdict.vec;
                st_q   <= ST_DONE;
              end
              ACT_PROBE: begin
                pend_q <= 1'b0;
                cp_q   <= verdict.cp;
                st_q   <= ST_REQ;
              end
              default: begin
                pend_q <= 1'b0;
                st_q   <= ST_DONE;
              end
            endcase
          end
        end
        ST_REQ: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (ev_probe_fail) begin
            pend_q <= 1'b1;
            vec_q  <= VEC_FLINE;
            st_q   <= ST_DONE;
          end else if (ev_probe_ok) begin
            pend_q <= 1'b0;
            st_q   <= ST_DONE;
          end
        end
        default: begin
          pend_q <= 1'b0;
          st_q   <= ST_IDLE;
        end
      endcase
    end
  end

  assign state      = st_q;
  assign cp_req     = (st_q == ST_REQ) || (st_q == ST_WAIT);
  assign cp_id      = cp_q;
  assign exc_valid  = (st_q == ST_DONE) && pend_q;
  assign exc_vector = vec_q;
endmodule

// File: rtl/opexc_classifier.sv
module opexc_classifier
  import opexc_pkg::*;
#(
  parameter logic [3:0]  CP_SPACE_TYPE = 4'h2,
  parameter logic [15:0] ILLEGAL_WORD  = 16'h4AFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [15:0]      opword,
  input  logic             supervisor,
  input  logic             mmu_ext_ok,
  input  logic [15:0]      ext_word,
  input  logic             bkpt_berr,
  input  logic             cp_ack,
  input  logic             cp_berr,
  output logic             ready,
  output logic             cp_req,
  output logic [3:0]       cp_space,
  output logic [CP_W-1:0]  cp_id,
  output logic             exc_valid,
  output logic [VEC_W-1:0] exc_vector,
  output logic [OFF_W-1:0] exc_offset
);
  verdict_t verdict;
  pst_e     state;
  logic     ev_accept;
  logic     ev_bkpt;
  logic     ev_probe_fail;
  logic     ev_probe_ok;

  opexc_decode #(.ILLEGAL_WORD(ILLEGAL_WORD)) u_decode (
    .opword     (opword),
    .supervisor (supervisor),
    .mmu_ext_ok (mmu_ext_ok),
    .ext_word   (ext_word),
    .verdict    (verdict)
  );

  opexc_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .dec_valid     (dec_valid),
    .bkpt_berr     (bkpt_berr),
    .verdict       (verdict),
    .cp_ack        (cp_ack),
    .cp_berr       (cp_berr),
    .state         (state),
    .cp_req        (cp_req),
    .cp_id         (cp_id),
    .exc_valid     (exc_valid),
    .exc_vector    (exc_vector),
    .ev_accept     (ev_accept),
    .ev_bkpt       (ev_bkpt),
    .ev_probe_fail (ev_probe_fail),
    .ev_probe_ok   (ev_probe_ok)
  );

  assign ready      = (state == ST_IDLE);
  assign cp_space   = cp_req ? CP_SPACE_TYPE : 4'h0;
  assign exc_offset = vec_to_offset(exc_vector);
endmodule

// File: rtl/opexc_checker.sv
module opexc_checker
  import opexc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic [15:0]      opword,
  input logic             bkpt_berr,
  input logic             cp_ack,
  input logic             cp_berr,
  input logic             ready,
  input logic             cp_req,
  input logic [3:0]       cp_space,
  input logic [CP_W-1:0]  cp_id,
  input logic             exc_valid,
  input logic [VEC_W-1:0] exc_vector,
  input logic [OFF_W-1:0] exc_offset,
  input logic             ev_probe_fail
);
  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !exc_valid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!cp_req && !exc_valid));

  p_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_offset[1:0] == 2'b00 && exc_offset[OFF_W-1:2] == exc_vector));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_req && !cp_ack && !cp_berr) |=> cp_req);

  p_req_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cp_req |-> (cp_space == 4'h2));

  p_req_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_req && $past(cp_req)) |-> $stable(cp_id));

  p_probe_berr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_req && $past(cp_req) && cp_berr) |=> (exc_valid && exc_vector == 8'd11));

  p_probe_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_probe_fail |=> (exc_valid && !cp_req));

  p_probe_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_req && $past(cp_req) && cp_ack && !cp_berr) |=> (!exc_valid && !cp_req));

  p_aline_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && dec_valid && !bkpt_berr && opword[15:12] == 4'hA) |=>
      (exc_valid && exc_vector == 8'd10));

  p_bkpt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && bkpt_berr) |=> (exc_valid && exc_vector == 8'd4));
endmodule

bind opexc_classifier opexc_checker u_opexc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .dec_valid     (dec_valid),
  .opword        (opword),
  .bkpt_berr     (bkpt_berr),
  .cp_ack        (cp_ack),
  .cp_berr       (cp_berr),
  .ready         (ready),
  .cp_req        (cp_req),
  .cp_space      (cp_space),
  .cp_id         (cp_id),
  .exc_valid     (exc_valid),
  .exc_vector    (exc_vector),
  .exc_offset    (exc_offset),
  .ev_probe_fail (ev_probe_fail)
);

// File: tb/opexc_classifier_bench.sv
module opexc_classifier_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic [15:0] opword = '0;
  logic        supervisor = 1'b0;
  logic        mmu_ext_ok = 1'b0;
  logic [15:0] ext_word = '0;
  logic        bkpt_berr = 1'b0;
  logic        cp_ack = 1'b0;
  logic        cp_berr = 1'b0;
  logic        ready;
  logic        cp_req;
  logic [3:0]  cp_space;
  logic [2:0]  cp_id;
  logic        exc_valid;
  logic [7:0]  exc_vector;
  logic [9:0]  exc_offset;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  opexc_classifier u_opexc_classifier (
    .clk, .rst_n, .dec_valid, .opword, .supervisor, .mmu_ext_ok, .ext_word,
    .bkpt_berr, .cp_ack, .cp_berr, .ready, .cp_req, .cp_space, .cp_id,
    .exc_valid, .exc_vector, .exc_offset
  );

  typedef struct packed {
    logic [15:0] op;
    logic        sup;
    logic        mok;
    logic [15:0] ext;
    logic        ev;
    logic [7:0]  vec;
    logic [3:0]  rq;
  } row_t;

  localparam int NROWS = 16;
  localparam row_t TBL [NROWS] = '{
    '{16'hA123, 1'b1, 1'b0, 16'h0000, 1'b1, 8'd10, 4'd1},  // R1 supervisor
    '{16'hAFFF, 1'b0, 1'b0, 16'h0000, 1'b1, 8'd10, 4'd1},  // R1 user
    '{16'h4AFC, 1'b1, 1'b0, 16'h0000, 1'b1, 8'd4,  4'd2},  // R2
    '{16'h4E45, 1'b0, 1'b0, 16'h0000, 1'b1, 8'd37, 4'd9},  // R9
    '{16'h4E4F, 1'b1, 1'b0, 16'h0000, 1'b1, 8'd47, 4'd9},  // R9 top
    '{16'h4E40, 1'b0, 1'b0, 16'h0000, 1'b1, 8'd32, 4'd9},  // R9 bottom
    '{16'hF000, 1'b1, 1'b0, 16'h0000, 1'b1, 8'd11, 4'd5},  // R5 supervisor
    '{16'hF000, 1'b0, 1'b0, 16'h0000, 1'b1, 8'd8,  4'd5},  // R5 user
    '{16'hF010, 1'b1, 1'b1, 16'h0000, 1'b0, 8'd0,  4'd5},  // R5 defined ext
    '{16'h4E7A, 1'b1, 1'b0, 16'h1805, 1'b1, 8'd4,  4'd3},  // R3 unknown reg
    '{16'h4E7B, 1'b1, 1'b0, 16'h0801, 1'b0, 8'd0,  4'd3},  // R3 known reg
    '{16'h4E7A, 1'b0, 1'b0, 16'h0002, 1'b1, 8'd8,  4'd3},  // R3 user
    '{16'h4E71, 1'b1, 1'b0, 16'h0000, 1'b0, 8'd0,  4'd13}, // R13
    '{16'h1234, 1'b0, 1'b0, 16'h0000, 1'b0, 8'd0,  4'd13}, // R13
    '{16'h4E50, 1'b1, 1'b0, 16'h0000, 1'b0, 8'd0,  4'd13}, // R13 near trap
    '{16'h4AFD, 1'b1, 1'b0, 16'h0000, 1'b0, 8'd0,  4'd13}  // R13 near illegal
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one decode and check the strobe in the following cycle, then its end.
  task automatic run_row(input row_t r);
    string tag;
    tag = $sformatf("R%0d", r.rq);
    @(negedge clk);
    opword = r.op; supervisor = r.sup; mmu_ext_ok = r.mok; ext_word = r.ext;
    dec_valid = 1'b1;
    @(negedge clk);
    dec_valid = 1'b0;
    chk(exc_valid == r.ev, tag, exc_valid, r.ev);
    if (r.ev) begin
      chk(exc_vector == r.vec, tag, exc_vector, r.vec);
      chk(exc_offset == 10'(r.vec) * 10'd4, "R10", exc_offset, r.vec * 4);
    end
    @(negedge clk);
    chk(exc_valid == 1'b0, "R11", exc_valid, 0);
    chk(ready == 1'b1, "R11", ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    chk(ready == 1'b1, "R12", ready, 1);
    chk(exc_valid == 1'b0, "R12", exc_valid, 0);
    chk(cp_req == 1'b0, "R12", cp_req, 0);

    for (int i = 0; i < NROWS; i++) run_row(TBL[i]);

    // R6 + R7: probe to coprocessor 1, held several cycles, ends in bus error
    @(negedge clk);
    opword = 16'hF200; supervisor = 1'b0; dec_valid = 1'b1;
    @(negedge clk);
    dec_valid = 1'b0;
    chk(cp_req == 1'b1, "R6", cp_req, 1);
    chk(cp_space == 4'h2, "R6", cp_space, 2);
    chk(cp_id == 3'd1, "R6", cp_id, 1);
    repeat (4) @(negedge clk);
    chk(cp_req == 1'b1, "R6", cp_req, 1);
    chk(exc_valid == 1'b0, "R6", exc_valid, 0);
    cp_berr = 1'b1; cp_ack = 1'b1;  // R7 berr wins over ack
    @(negedge clk);
    cp_berr = 1'b0; cp_ack = 1'b0;
    chk(exc_valid == 1'b1, "R7", exc_valid, 1);
    chk(exc_vector == 8'd11, "R7", exc_vector, 11);
    chk(exc_offset == 10'd44, "R10", exc_offset, 44);
    chk(cp_req == 1'b0, "R7", cp_req, 0);
    @(negedge clk);
    chk(exc_valid == 1'b0, "R11", exc_valid, 0);

    // R6 + R8: coprocessor 7, ack in first request cycle ignored, then normal ack
    @(negedge clk);
    opword = 16'hFE00; dec_valid = 1'b1;
    @(negedge clk);
    dec_valid = 1'b0;
    chk(cp_id == 3'd7, "R6", cp_id, 7);
    cp_ack = 1'b1;
    @(negedge clk);
    cp_ack = 1'b0;
    chk(cp_req == 1'b1, "R6", cp_req, 1);
    // R11: a decode while busy is ignored
    opword = 16'hA000; dec_valid = 1'b1;
    @(negedge clk);
    dec_valid = 1'b0;
    chk(cp_req == 1'b1, "R11", cp_req, 1);
    chk(exc_valid == 1'b0, "R11", exc_valid, 0);
    cp_ack = 1'b1;
    @(negedge clk);
    cp_ack = 1'b0;
    chk(cp_req == 1'b0, "R8", cp_req, 0);
    chk(exc_valid == 1'b0, "R8", exc_valid, 0);
    @(negedge clk);
    chk(exc_valid == 1'b0, "R11", exc_valid, 0);
    chk(ready == 1'b1, "R8", ready, 1);
    @(negedge clk);
    chk(exc_valid == 1'b0, "R11", exc_valid, 0);

    // R4: breakpoint bus error beats a simultaneous TRAP decode
    @(negedge clk);
    opword = 16'h4E43; dec_valid = 1'b1; bkpt_berr = 1'b1;
    @(negedge clk);
    dec_valid = 1'b0; bkpt_berr = 1'b0;
    chk(exc_valid == 1'b1, "R4", exc_valid, 1);
    chk(exc_vector == 8'd4, "R4", exc_vector, 4);
    @(negedge clk);
    chk(exc_valid == 1'b0, "R4", exc_valid, 0);
    @(negedge clk);
    chk(exc_valid == 1'b0, "R4", exc_valid, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule